// File: doc/BRIEF.md
# Masked-Write GPIO Port Register Bank

This block holds the control registers for one bank of general-purpose pins. The bank has a parameterised number of ports; each port has a parameterised number of pins, and the defaults are four ports of eight pins, 32 pins in all. A plain word-addressed register bus reaches the registers. Each port has configuration, drive-enable, output-level, interrupt-enable, interrupt-type, debounce-enable and debounce-count registers, plus a read-only view of its synchronised pin inputs. The block drives the pin output levels and drive enables. It passes the interrupt and debounce settings on to the separate detector and filter blocks.

Every control register is reachable at two addresses. A write to the direct address replaces the whole port byte. A write to the masked alias changes only the pins that the upper byte of the write data selects. Software on several agents can therefore change single pins of a shared port without a read-modify-write sequence. A pin drives only while both its configuration bit and its drive-enable bit are set. Software can therefore load the output level first and turn on the driver afterwards.

Top module: `gpb_regbank`

## Requirements
- R1: After reset, every configuration, drive-enable, output, interrupt-enable, interrupt-type, debounce-enable and debounce-count bit is 0, so `pin_oe` and `pin_out` are all zero.
- R2: The word address is {alias, kind[3:0], port[1:0]}: bit 6 selects the masked alias region, bits 5:2 the register kind and bits 1:0 the port. A direct write (bit 6 = 0) loads `bus_wdata[7:0]` into the addressed register of the addressed port only. Kind codes: 0 configuration, 1 drive enable, 2 output level, 3 pin input (direct) or debounce enable (alias), 5 interrupt enable, 6 interrupt type, 15 debounce count.
- R3: In a write to the alias region, `bus_wdata` bit 8+n is the write enable for pin n and bit n is its new value. Pins whose enable bit is 0 keep their old value.
- R4: `pin_oe` for a pin is 1 only when both its configuration bit and its drive-enable bit are 1. `pin_out` always shows the output-level register, so a level written before the driver is enabled is the level that appears first.
- R5: A direct read of kind 3 returns the addressed port's pins as sampled by a two-flop synchroniser, two clock edges behind `pin_in`. A write to that address has no effect.
- R6: Read data carries the register in bits 7:0 and zero in all upper bits. An alias address reads the same register as its direct address. Kinds 4, 7 and the other unlisted codes read 0, and writes to them have no effect.
- R7: Debounce enable exists only in the alias region, at kind 3. It is written with the masked rule of R3 and is read back there.
- R8: Debounce count exists only at direct kind 15 and takes a full-byte write. Alias kind 15 reads 0, and a write to it leaves the count unchanged.
- R9: No register changes in a cycle where `bus_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Word address {alias, kind, port} |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data; mask in bits 15:8 for alias writes |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Drive enable per pin |
| irq_en_o | output | 32 | Interrupt enable per pin, to the detector |
| irq_type_o | output | 32 | Interrupt type bit per pin, to the detector |
| dbc_en_o | output | 32 | Debounce enable per pin, to the filter |
| dbc_cnt_o | output | 32 | Debounce count, one byte per port |

## Verification
The hardest case to reach is a masked write that lands on a register whose other pins already hold a mix of ones and zeros. Only then does a wrong merge, such as an inverted mask, a shifted mask or a full-byte overwrite, show up at the pins. The stimulus first loads a known non-uniform byte with a direct write and then applies a partial mask. A long phase of random addresses and data follows, with the pins changing as well, and a behavioural model is compared with the pins and the read data on every clock. That phase also reaches the alias-only debounce enable, the direct-only debounce count and writes to the input address.

// File: rtl/gpb_pkg.sv
// Shared definitions for the GPIO port register bank.
// Assumes the word address layout {alias, kind[3:0], port}.
package gpb_pkg;
    typedef enum logic [3:0] {
        K_CFG  = 4'd0,   // pin is under GPIO control
        K_DRV  = 4'd1,   // drive enable
        K_OUT  = 4'd2,   // output level
        K_PIN  = 4'd3,   // direct: synced input; alias: debounce enable
        K_IEN  = 4'd5,   // interrupt enable
        K_ITYP = 4'd6,   // interrupt type
        K_DCNT = 4'd15   // debounce count (direct only)
    } reg_kind_e;
endpackage

// File: rtl/gpb_sync.sv
// Two-flop synchroniser for the asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is given across bits.
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Purpose: shift the raw levels through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpb_port_regs.sv
// Register set of one port: direct full-byte writes and masked alias writes.
// Assumes the write enable is already qualified with the port select.
module gpb_port_regs
    import gpb_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  alias_wr,
    input  logic [3:0]            kind,
    input  logic [2*PORT_W-1:0]   wbits,
    output logic [PORT_W-1:0]     cfg_q,
    output logic [PORT_W-1:0]     drv_q,
    output logic [PORT_W-1:0]     out_q,
    output logic [PORT_W-1:0]     ien_q,
    output logic [PORT_W-1:0]     ityp_q,
    output logic [PORT_W-1:0]     den_q,
    output logic [PORT_W-1:0]     dcnt_q
);
    logic [PORT_W-1:0] sel_m;
    logic [PORT_W-1:0] new_v;

    assign sel_m = wbits[2*PORT_W-1:PORT_W];
    assign new_v = wbits[PORT_W-1:0];

    // Purpose: next value of a register under direct or masked write.
    function automatic logic [PORT_W-1:0] merge(input logic [PORT_W-1:0] old,
                                                input logic              msk,
                                                input logic [PORT_W-1:0] m,
                                                input logic [PORT_W-1:0] v);
        return msk ? ((old & ~m) | (v & m)) : v;
    endfunction

    // Purpose: update the register chosen by kind on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            drv_q  <= '0;
            out_q  <= '0;
            ien_q  <= '0;
            ityp_q <= '0;
            den_q  <= '0;
            dcnt_q <= '0;
        end else if (wr_en) begin
            case (kind)
                K_CFG:  cfg_q  <= merge(cfg_q,  alias_wr, sel_m, new_v);
                K_DRV:  drv_q  <= merge(drv_q,  alias_wr, sel_m, new_v);
                K_OUT:  out_q  <= merge(out_q,  alias_wr, sel_m, new_v);
                K_IEN:  ien_q  <= merge(ien_q,  alias_wr, sel_m, new_v);
                K_ITYP: ityp_q <= merge(ityp_q, alias_wr, sel_m, new_v);
                K_PIN:  if (alias_wr) den_q <= merge(den_q, 1'b1, sel_m, new_v);
                K_DCNT: if (!alias_wr) dcnt_q <= new_v;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpb_regbank.sv
// Register bank for one GPIO bank: address decode, per-port registers,
// input synchroniser and read mux. Assumes DATA_W >= 2*PORT_W and a
// power-of-two NUM_PORTS of at least 2.
module gpb_regbank
    import gpb_pkg::*;
#(
    parameter  int NUM_PORTS = 4,
    parameter  int PORT_W    = 8,
    parameter  int DATA_W    = 32,
    localparam int PORT_AW   = $clog2(NUM_PORTS),
    localparam int ADDR_W    = PORT_AW + 5,
    localparam int NPIN      = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic [NPIN-1:0]   irq_en_o,
    output logic [NPIN-1:0]   irq_type_o,
    output logic [NPIN-1:0]   dbc_en_o,
    output logic [NPIN-1:0]   dbc_cnt_o
);
    logic [PORT_AW-1:0] port_sel;
    logic [3:0]         kind;
    logic               alias_sel;
    logic [NPIN-1:0]    pin_sync;
    logic [PORT_W-1:0]  rd_byte;
    logic               unused_wdata;

    logic [PORT_W-1:0] cfg_a  [NUM_PORTS];
    logic [PORT_W-1:0] drv_a  [NUM_PORTS];
    logic [PORT_W-1:0] out_a  [NUM_PORTS];
    logic [PORT_W-1:0] ien_a  [NUM_PORTS];
    logic [PORT_W-1:0] ityp_a [NUM_PORTS];
    logic [PORT_W-1:0] den_a  [NUM_PORTS];
    logic [PORT_W-1:0] dcnt_a [NUM_PORTS];
    logic [PORT_W-1:0] sync_a [NUM_PORTS];

    assign port_sel     = bus_addr[PORT_AW-1:0];
    assign kind         = bus_addr[PORT_AW+3:PORT_AW];
    assign alias_sel    = bus_addr[PORT_AW+4];
    assign unused_wdata = ^bus_wdata[DATA_W-1:2*PORT_W];

    gpb_sync #(.W(NPIN)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpb_port_regs #(.PORT_W(PORT_W)) regs_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_we && (port_sel == PORT_AW'(p))),
            .alias_wr (alias_sel),
            .kind     (kind),
            .wbits    (bus_wdata[2*PORT_W-1:0]),
            .cfg_q    (cfg_a[p]),
            .drv_q    (drv_a[p]),
            .out_q    (out_a[p]),
            .ien_q    (ien_a[p]),
            .ityp_q   (ityp_a[p]),
            .den_q    (den_a[p]),
            .dcnt_q   (dcnt_a[p])
        );

        assign sync_a[p]                        = pin_sync[p*PORT_W +: PORT_W];
        assign pin_out[p*PORT_W +: PORT_W]      = out_a[p];
        assign pin_oe[p*PORT_W +: PORT_W]       = cfg_a[p] & drv_a[p];
        assign irq_en_o[p*PORT_W +: PORT_W]     = ien_a[p];
        assign irq_type_o[p*PORT_W +: PORT_W]   = ityp_a[p];
        assign dbc_en_o[p*PORT_W +: PORT_W]     = den_a[p];
        assign dbc_cnt_o[p*PORT_W +: PORT_W]    = dcnt_a[p];
    end

    // Purpose: select the addressed port byte for the read bus.
    always_comb begin
        case (kind)
            K_CFG:   rd_byte = cfg_a[port_sel];
            K_DRV:   rd_byte = drv_a[port_sel];
            K_OUT:   rd_byte = out_a[port_sel];
            K_IEN:   rd_byte = ien_a[port_sel];
            K_ITYP:  rd_byte = ityp_a[port_sel];
            K_PIN:   rd_byte = alias_sel ? den_a[port_sel] : sync_a[port_sel];
            K_DCNT:  rd_byte = alias_sel ? '0 : dcnt_a[port_sel];
            default: rd_byte = '0;
        endcase
    end

    assign bus_rdata = DATA_W'(rd_byte);
endmodule

// File: rtl/gpb_regbank_chk.sv
// Property checker for gpb_regbank, attached with bind below.
// Assumes the same parameters as the bound instance.
module gpb_regbank_chk
    import gpb_pkg::*;
#(
    parameter  int NUM_PORTS = 4,
    parameter  int PORT_W    = 8,
    parameter  int DATA_W    = 32,
    localparam int PORT_AW   = $clog2(NUM_PORTS),
    localparam int ADDR_W    = PORT_AW + 5,
    localparam int NPIN      = NUM_PORTS * PORT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPIN-1:0]   pin_in,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe
);
    logic [PORT_AW-1:0] c_port;
    logic [3:0]         c_kind;
    logic               c_alias;
    logic [NPIN-1:0]    port_mask;
    logic [NPIN-1:0]    wmask_exp;
    logic [NPIN-1:0]    wval_exp;
    logic [NPIN-1:0]    in_d1;
    logic [NPIN-1:0]    in_d2;
    logic [1:0]         age;
    logic               was_in_reset;
    logic               unused_chk;

    assign c_port     = bus_addr[PORT_AW-1:0];
    assign c_kind     = bus_addr[PORT_AW+3:PORT_AW];
    assign c_alias    = bus_addr[PORT_AW+4];
    assign port_mask  = NPIN'({PORT_W{1'b1}}) << (int'(c_port) * PORT_W);
    assign wmask_exp  = NPIN'(bus_wdata[2*PORT_W-1:PORT_W]) << (int'(c_port) * PORT_W);
    assign wval_exp   = NPIN'(bus_wdata[PORT_W-1:0]) << (int'(c_port) * PORT_W);
    assign unused_chk = ^bus_wdata[DATA_W-1:2*PORT_W];

    // Purpose: delayed pin copy and cycles-since-reset count.
    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
        if (!rst_n) begin
            in_d1 <= '0;
            in_d2 <= '0;
            age   <= '0;
        end else begin
            in_d1 <= pin_in;
            in_d2 <= in_d1;
            if (age != 2'd2) age <= age + 2'd1;
        end
    end

    // Purpose: outputs are cleared on the first cycle after reset.
    always @(posedge clk) begin
        if (rst_n && was_in_reset)
            assert_reset_clear_R1: assert (pin_oe == '0 && pin_out == '0);
    end

    assert_masked_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && c_alias && c_kind == K_OUT)
        |=> (((pin_out ^ $past(pin_out)) & ~$past(wmask_exp)) == '0));

    assert_cfg_gates_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !c_alias && c_kind == K_CFG)
        |=> ((pin_oe & $past(port_mask) & ~$past(wval_exp)) == '0));

    assert_input_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !c_alias && c_kind == K_PIN)
        |=> ($stable(pin_out) && $stable(pin_oe)));

    assert_input_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && !c_alias && c_kind == K_PIN)
        |-> (bus_rdata[PORT_W-1:0] == in_d2[int'(c_port)*PORT_W +: PORT_W]));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (bus_rdata[DATA_W-1:PORT_W] == '0));

    assert_unused_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_kind == 4'd4 || c_kind == 4'd7) |-> (bus_rdata == '0));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpb_regbank gpb_regbank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W),
    .DATA_W    (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpb_regbank_tb_top.sv
// Bench for gpb_regbank: directed cases plus a random phase, with a
// behavioural model compared on every clock.
module gpb_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, irq_en_o, irq_type_o, dbc_en_o, dbc_cnt_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Model state, one byte per port.
    logic [7:0] m_cfg [4];
    logic [7:0] m_drv [4];
    logic [7:0] m_out [4];
    logic [7:0] m_ien [4];
    logic [7:0] m_ityp[4];
    logic [7:0] m_den [4];
    logic [7:0] m_dcnt[4];
    logic [31:0] m_s1, m_s2;

    always #5 clk = ~clk;

    gpb_regbank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .irq_en_o   (irq_en_o),
        .irq_type_o (irq_type_o),
        .dbc_en_o   (dbc_en_o),
        .dbc_cnt_o  (dbc_cnt_o)
    );

    function automatic logic [6:0] A(input bit al, input int k, input int p);
        return {al, 4'(k), 2'(p)};
    endfunction

    function automatic logic [7:0] upd(input logic [7:0] old, input bit al,
                                       input logic [15:0] d);
        return al ? ((old & ~d[15:8]) | (d[7:0] & d[15:8])) : d[7:0];
    endfunction

    // Model: register updates from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 4; p++) begin
                m_cfg[p] = 0; m_drv[p] = 0; m_out[p] = 0; m_ien[p] = 0;
                m_ityp[p] = 0; m_den[p] = 0; m_dcnt[p] = 0;
            end
            m_s1 = 0; m_s2 = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (bus_we) begin
                automatic int p = int'(bus_addr[1:0]);
                automatic bit al = bus_addr[6];
                case (int'(bus_addr[5:2]))
                    0:  m_cfg[p]  = upd(m_cfg[p],  al, bus_wdata[15:0]);
                    1:  m_drv[p]  = upd(m_drv[p],  al, bus_wdata[15:0]);
                    2:  m_out[p]  = upd(m_out[p],  al, bus_wdata[15:0]);
                    3:  if (al) m_den[p] = upd(m_den[p], 1'b1, bus_wdata[15:0]);
                    5:  m_ien[p]  = upd(m_ien[p],  al, bus_wdata[15:0]);
                    6:  m_ityp[p] = upd(m_ityp[p], al, bus_wdata[15:0]);
                    15: if (!al) m_dcnt[p] = bus_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] mread(input logic [6:0] a);
        automatic int p = int'(a[1:0]);
        automatic bit al = a[6];
        case (int'(a[5:2]))
            0:  return {24'h0, m_cfg[p]};
            1:  return {24'h0, m_drv[p]};
            2:  return {24'h0, m_out[p]};
            3:  return {24'h0, al ? m_den[p] : m_s2[p*8 +: 8]};
            5:  return {24'h0, m_ien[p]};
            6:  return {24'h0, m_ityp[p]};
            15: return {24'h0, al ? 8'h00 : m_dcnt[p]};
            default: return 32'h0;
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            automatic logic [31:0] e_oe, e_out;
            for (int p = 0; p < 4; p++) begin
                e_oe[p*8 +: 8]  = m_cfg[p] & m_drv[p];
                e_out[p*8 +: 8] = m_out[p];
            end
            tests++;
            if (pin_oe !== e_oe || pin_out !== e_out) begin
                fails++;
                $display("FAIL R4 pins: oe=%h out=%h expected oe=%h out=%h",
                         pin_oe, pin_out, e_oe, e_out);
            end
            tests++;
            if (bus_rdata !== mread(bus_addr)) begin
                fails++;
                $display("FAIL R6 read addr=%h: got %h expected %h",
                         bus_addr, bus_rdata, mread(bus_addr));
            end
        end
    end

    task automatic drive(input bit we, input logic [6:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        drive(1'b1, a, d);
        drive(1'b0, a, 32'h0);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [6:0] a, input logic [31:0] exp);
        drive(1'b0, a, 32'h0);
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 cfg port0", A(0, 0, 0), 32'h0);
        chk("R1 pin_oe", pin_oe, 32'h0);
        rd_chk("R1 irq type port3", A(0, 6, 3), 32'h0);

        // R2: direct byte write to one port
        wr(A(0, 2, 1), 32'h0000_00A5);
        rd_chk("R2 out port1", A(0, 2, 1), 32'h0000_00A5);
        chk("R2 pin_out", pin_out, 32'h0000_A500);

        // R3: masked write clears low nibble only
        wr(A(1, 2, 1), 32'h0000_0FF0);
        rd_chk("R3 out port1 after mask", A(0, 2, 1), 32'h0000_00A0);
        rd_chk("R6 alias reads same reg", A(1, 2, 1), 32'h0000_00A0);

        // R4: level preset before driver is enabled
        wr(A(0, 2, 2), 32'h0000_003C);
        @(negedge clk);
        chk("R4 preset level", pin_out[23:16], 32'h3C);
        chk("R4 no drive yet", pin_oe, 32'h0);
        wr(A(1, 1, 2), 32'h0000_FFFF);
        @(negedge clk);
        chk("R4 drive without cfg", pin_oe, 32'h0);
        wr(A(0, 0, 2), 32'h0000_000F);
        @(negedge clk);
        chk("R4 cfg gates drive", pin_oe, 32'h000F_0000);

        // R5: synced input view, writes ignored
        pin_in = 32'h1234_5678;
        repeat (3) @(posedge clk);
        rd_chk("R5 input port3", A(0, 3, 3), 32'h12);
        wr(A(0, 3, 3), 32'h0000_FFFF);
        rd_chk("R5 input write ignored", A(0, 3, 3), 32'h12);

        // R7: debounce enable only in alias region
        wr(A(1, 3, 0), 32'h0000_FF81);
        rd_chk("R7 debounce enable", A(1, 3, 0), 32'h81);
        chk("R7 debounce enable pins", dbc_en_o, 32'h0000_0081);
        rd_chk("R7 direct kind3 is input", A(0, 3, 0), 32'h78);

        // R8: debounce count direct only
        wr(A(0, 15, 1), 32'h0000_0040);
        rd_chk("R8 count", A(0, 15, 1), 32'h40);
        wr(A(1, 15, 1), 32'h0000_FFFF);
        rd_chk("R8 alias write ignored", A(0, 15, 1), 32'h40);
        rd_chk("R8 alias read zero", A(1, 15, 1), 32'h0);

        // R9: no write strobe, no change
        drive(1'b0, A(0, 0, 2), 32'h0000_00FF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 idle keeps drive", pin_oe, 32'h000F_0000);

        // R6: upper bits zero, unused kinds read zero
        wr(A(0, 5, 0), 32'hFFFF_FFFF);
        rd_chk("R6 upper bits zero", A(0, 5, 0), 32'h0000_00FF);
        wr(A(0, 4, 0), 32'hFFFF_FFFF);
        rd_chk("R6 unused kind4", A(0, 4, 0), 32'h0);
        rd_chk("R6 unused kind7", A(1, 7, 2), 32'h0);

        // Random phase: R2 R3 R7 R8 under the per-cycle model.
        for (int i = 0; i < 2000; i++) begin
            if (i % 7 == 0) pin_in = $urandom;
            drive(($urandom % 3) != 0, 7'($urandom), $urandom);
        end
        drive(1'b0, A(0, 0, 0), 32'h0);
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule